// File: doc/BRIEF.md
# Single-Channel DMA Sequencing Engine with Repeat and Reload Modes

This block is the control engine of one DMA channel. Software programs a source address, a destination address and a unit count through a small register port, along with backup copies of all three. The engine then asks the bus for one transfer unit at a time. Each granted unit moves both addresses by the programmed step and lowers the count by one. The data path is not part of this block: it only supplies the addresses and the unit size for each command.

There are three ways to finish a count. In normal mode the channel stops and raises an end flag. In repeat mode it refills the addresses and the count from the backups. It raises a half-way flag when the count reaches half of the backup count, and it raises the end flag each time it wraps. In reload mode the count holds three byte fields: a unit counter in bits [7:0], a number of remaining reloads in bits [15:8] and a reload value in bits [23:16]. Each time the unit counter empties, the addresses return to their backups and the unit counter is refilled from the reload value.

Requests come from one of three sources: an external request line sampled by level, the same line sampled by rising edge, or an automatic request that is always present. The engine stops at once when a non-maskable-event flag or an address-error flag is set, or when software clears the channel enable or the global enable. A single interrupt line reports the flags that software has enabled.

Top module: `dma_chan_engine`

## Requirements
- R1: Each granted unit lowers the count by one and moves each address by its step. The step is set by the unit size code (bits [10:9] of CTRL: 0/1/2/3 give 1/2/4/8 bytes) and by that side's step code (source bits [6:5], destination bits [8:7]: 0 hold, 1 add, 2 subtract, 3 hold).
- R2: A unit is requested only when all of the following hold: channel enable (CTRL bit 0) is 1, the global enable (GLB bit 0) is 1, and the event flag (GLB bit 1), the address-error flag (GLB bit 2) and the end flag (CTRL bit 3) are all 0. R3 gives the one exception.
- R3: In repeat mode (CTRL [12:11] = 1), a request is still accepted while the end flag is 1, provided the half-way interrupt enable (CTRL bit 2) is 1 and the half-way flag (CTRL bit 4) is 0.
- R4: If the event flag or the address-error flag becomes 1, or either enable is cleared, a pending bus request is withdrawn on the next cycle. The count is left unchanged. A pulse on `nmi_evt` sets the event flag, and a pulse on `addr_err_evt` sets the address-error flag.
- R5: In repeat mode, when a unit brings the count to half of the backup count (the backup count shifted right by one), the half-way flag is set.
- R6: In repeat mode, when a unit brings the count to 0, the source, destination and count are refilled from their backups and the end flag is set.
- R7: In reload mode (CTRL [12:11] = 2), a write to CNT also copies bits [7:0] into a backup-low field, read back at CNTB bits [31:24]. When bits [7:0] reach 0 while bits [15:8] are nonzero, bits [15:8] drop by one, bits [23:16] are copied into bits [7:0], and both addresses return to their backups. When bits [7:0] reach 0 while bits [15:8] are zero, the end flag is set.
- R8: In normal mode (CTRL [12:11] = 0), when a unit brings the count to 0 the end flag is set, and `irq` rises if the interrupt enable (CTRL bit 1) is 1.
- R9: With CTRL bit 13 set, requests are automatic. Otherwise, with CTRL bit 14 = 0 a high `dreq` level requests a unit. With CTRL bit 14 = 1 each rising edge of `dreq` stores exactly one request, which is consumed when its unit is requested.
- R10: Writing 0 to the end flag or the half-way flag clears it, and writing 1 leaves it unchanged. The event and address-error flags behave the same way. `irq` is high exactly when an enabled flag (end with bit 1, half-way with bit 2) is set.
- R11: `bus_req` stays high until `bus_gnt` is seen, and one grant completes exactly one unit. The cycle after a grant, `bus_req` is low.

Register map (`wr_addr`/`rd_addr`): 0 SRC, 1 DST, 2 CNT, 3 CTRL, 4 SRCB, 5 DSTB, 6 CNTB, 7 GLB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write select |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read select |
| rd_data | output | DW | Register read data (combinational) |
| dreq | input | 1 | External transfer request |
| nmi_evt | input | 1 | Sets the event flag |
| addr_err_evt | input | 1 | Sets the address-error flag |
| bus_req | output | 1 | Request for one transfer unit |
| bus_gnt | input | 1 | Grant; completes the current unit |
| bus_src | output | AW | Source address of the current unit |
| bus_dst | output | AW | Destination address of the current unit |
| bus_size | output | 2 | Unit size code |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses and data, and a 24-bit count. A 24-bit count is the smallest width that holds all three byte fields of reload mode, so one reload cycle (reload value 2, one reload remaining) ends in four units. Repeat mode uses a backup count of 4, so both the half-way point and the wrap are reached within four grants. Small counts in normal mode leave room to cover every request source, the abort path and the flag-clearing rules in one short run.

// File: rtl/dma_chan_pkg.sv
// Package: shared register selects, mode and step codes, control-word layout.
// Assumes the count width is at least 24 bits wherever reload mode is used.
package dma_chan_pkg;
    localparam logic [2:0] REG_SRC  = 3'd0;
    localparam logic [2:0] REG_DST  = 3'd1;
    localparam logic [2:0] REG_CNT  = 3'd2;
    localparam logic [2:0] REG_CTRL = 3'd3;
    localparam logic [2:0] REG_SRCB = 3'd4;
    localparam logic [2:0] REG_DSTB = 3'd5;
    localparam logic [2:0] REG_CNTB = 3'd6;
    localparam logic [2:0] REG_GLB  = 3'd7;

    localparam logic [1:0] MODE_NORMAL = 2'd0;
    localparam logic [1:0] MODE_REPEAT = 2'd1;
    localparam logic [1:0] MODE_RELOAD = 2'd2;

    localparam logic [1:0] STEP_UP   = 2'd1;
    localparam logic [1:0] STEP_DOWN = 2'd2;

    // Control word, bit 0 at the bottom of the list.
    typedef struct packed {
        logic       edge_det;   // 14
        logic       auto_req;   // 13
        logic [1:0] mode;       // 12:11
        logic [1:0] size;       // 10:9
        logic [1:0] dst_step;   // 8:7
        logic [1:0] src_step;   // 6:5
        logic       half_flag;  // 4
        logic       end_flag;   // 3
        logic       half_ie;    // 2
        logic       irq_en;     // 1
        logic       chan_en;    // 0
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dma_addr_step.sv
// Address stepper: next address after one unit for one side.
// Assumes the size code selects 1, 2, 4 or 8 bytes; codes 0 and 3 hold.
module dma_addr_step
    import dma_chan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    step,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr_next
);
    logic [AW-1:0] delta;

    // Compute byte delta and apply according to the step code.
    always_comb begin
        delta = AW'(1) << size;
        case (step)
            STEP_UP:   addr_next = addr + delta;
            STEP_DOWN: addr_next = addr - delta;
            default:   addr_next = addr;
        endcase
    end
endmodule

// File: rtl/dma_count_unit.sv
// Count unit: next count and end/half/refill events for one completed unit.
// Assumes CW >= 24 so that reload mode finds its three byte fields.
module dma_count_unit
    import dma_chan_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cntb,
    input  logic [1:0]    mode,
    output logic [CW-1:0] cnt_next,
    output logic          hit_end,
    output logic          hit_half,
    output logic          refill_addr
);
    logic [CW-1:0] dec;
    logic [7:0]    lo_dec;

    // Decide next count and events from the mode.
    always_comb begin
        dec         = cnt - CW'(1);
        lo_dec      = cnt[7:0] - 8'd1;
        cnt_next    = dec;
        hit_end     = 1'b0;
        hit_half    = 1'b0;
        refill_addr = 1'b0;
        case (mode)
            MODE_REPEAT: begin
                hit_half = (dec == (cntb >> 1));
                if (dec == '0) begin
                    cnt_next    = cntb;
                    refill_addr = 1'b1;
                    hit_end     = 1'b1;
                end
            end
            MODE_RELOAD: begin
                cnt_next = {cnt[CW-1:8], lo_dec};
                if (lo_dec == 8'd0) begin
                    if (cnt[15:8] == 8'd0) begin
                        hit_end = 1'b1;
                    end else begin
                        cnt_next    = {cnt[CW-1:16], cnt[15:8] - 8'd1, cnt[23:16]};
                        refill_addr = 1'b1;
                    end
                end
            end
            default: hit_end = (dec == '0);
        endcase
    end
endmodule

// File: rtl/dma_req_detect.sv
// Request detector: level, rising-edge or automatic request source.
// Assumes 'issue' pulses in the cycle a unit request is raised; an edge
// arriving in that same cycle is kept for the next unit.
module dma_req_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic edge_mode,
    input  logic auto_mode,
    input  logic issue,
    output logic pending
);
    logic dreq_q;
    logic latch_q;
    logic rise;

    assign rise = dreq && !dreq_q;

    // Delay dreq and hold one stored request per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dreq_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            dreq_q  <= dreq;
            latch_q <= edge_mode && (rise || (latch_q && !issue));
        end
    end

    // Pick the request source.
    assign pending = auto_mode ? 1'b1 : (edge_mode ? latch_q : dreq);

    p_edge_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && !auto_mode && issue && !rise) |=> !latch_q);
endmodule

// File: rtl/dma_chan_engine.sv
// DMA channel engine: register file, request gating, one-unit bus handshake,
// count/address update in normal, repeat and reload modes, and interrupt.
// Assumes AW <= DW and CW <= DW - 8; a register write wins over a same-cycle
// hardware update of that register.
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          dreq,
    input  logic          nmi_evt,
    input  logic          addr_err_evt,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic [AW-1:0] bus_src,
    output logic [AW-1:0] bus_dst,
    output logic [1:0]    bus_size,
    output logic          irq
);
    localparam int NSIDE = 2;

    ctrl_t         ctrl_q, ctrl_wr;
    logic [AW-1:0] src_q, dst_q, srcb_q, dstb_q;
    logic [CW-1:0] cnt_q, cntb_q;
    logic [7:0]    blo_q;
    logic          master_q, nmi_q, ae_q, req_q;
    logic          abort, can_start, pending, issue, done;
    logic [CW-1:0] cnt_next;
    logic          hit_end, hit_half, refill_addr;
    logic [AW-1:0] side_cur  [NSIDE];
    logic [AW-1:0] side_nxt  [NSIDE];
    logic [1:0]    side_step [NSIDE];

    // Gate requests from enables, fault flags and the end-flag rule.
    always_comb begin
        abort     = !ctrl_q.chan_en || !master_q || nmi_q || ae_q;
        can_start = !abort && (!ctrl_q.end_flag ||
                    (ctrl_q.mode == MODE_REPEAT && ctrl_q.half_ie && !ctrl_q.half_flag));
        issue     = !req_q && can_start && pending;
        done      = req_q && bus_gnt && !abort;
    end

    dma_req_detect u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .dreq      (dreq),
        .edge_mode (ctrl_q.edge_det),
        .auto_mode (ctrl_q.auto_req),
        .issue     (issue),
        .pending   (pending)
    );

    dma_count_unit #(.CW(CW)) u_cnt (
        .cnt         (cnt_q),
        .cntb        (cntb_q),
        .mode        (ctrl_q.mode),
        .cnt_next    (cnt_next),
        .hit_end     (hit_end),
        .hit_half    (hit_half),
        .refill_addr (refill_addr)
    );

    assign side_cur[0]  = src_q;
    assign side_cur[1]  = dst_q;
    assign side_step[0] = ctrl_q.src_step;
    assign side_step[1] = ctrl_q.dst_step;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_addr_step #(.AW(AW)) u_step (
            .addr      (side_cur[s]),
            .step      (side_step[s]),
            .size      (ctrl_q.size),
            .addr_next (side_nxt[s])
        );
    end

    // Control word as written: flags may only be cleared by software.
    always_comb begin
        ctrl_wr           = ctrl_t'(wr_data[CTRL_W-1:0]);
        ctrl_wr.end_flag  = ctrl_q.end_flag  && wr_data[3];
        ctrl_wr.half_flag = ctrl_q.half_flag && wr_data[4];
    end

    // One-unit handshake: raise, hold until grant, drop on grant or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
        end else if (req_q) begin
            if (abort || bus_gnt) req_q <= 1'b0;
        end else if (issue) begin
            req_q <= 1'b1;
        end
    end

    // Register file: unit updates first, software writes and fault events last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            srcb_q   <= '0;
            dstb_q   <= '0;
            cnt_q    <= '0;
            cntb_q   <= '0;
            blo_q    <= '0;
            master_q <= 1'b0;
            nmi_q    <= 1'b0;
            ae_q     <= 1'b0;
        end else begin
            if (done) begin
                cnt_q <= cnt_next;
                src_q <= refill_addr ? srcb_q : side_nxt[0];
                dst_q <= refill_addr ? dstb_q : side_nxt[1];
                if (hit_end)  ctrl_q.end_flag  <= 1'b1;
                if (hit_half) ctrl_q.half_flag <= 1'b1;
            end
            if (wr_en) begin
                case (wr_addr)
                    REG_SRC:  src_q  <= AW'(wr_data);
                    REG_DST:  dst_q  <= AW'(wr_data);
                    REG_CNT: begin
                        cnt_q <= CW'(wr_data);
                        blo_q <= wr_data[7:0];
                    end
                    REG_CTRL: ctrl_q <= ctrl_wr;
                    REG_SRCB: srcb_q <= AW'(wr_data);
                    REG_DSTB: dstb_q <= AW'(wr_data);
                    REG_CNTB: cntb_q <= CW'(wr_data);
                    default: begin
                        master_q <= wr_data[0];
                        nmi_q    <= nmi_q && wr_data[1];
                        ae_q     <= ae_q && wr_data[2];
                    end
                endcase
            end
            if (nmi_evt)      nmi_q <= 1'b1;
            if (addr_err_evt) ae_q  <= 1'b1;
        end
    end

    // Register read mux.
    always_comb begin
        case (rd_addr)
            REG_SRC:  rd_data = DW'(src_q);
            REG_DST:  rd_data = DW'(dst_q);
            REG_CNT:  rd_data = DW'(cnt_q);
            REG_CTRL: rd_data = DW'(ctrl_q);
            REG_SRCB: rd_data = DW'(srcb_q);
            REG_DSTB: rd_data = DW'(dstb_q);
            REG_CNTB: rd_data = DW'(cntb_q) | (DW'(blo_q) << (DW - 8));
            default:  rd_data = DW'({ae_q, nmi_q, master_q});
        endcase
    end

    // Bus command and interrupt outputs.
    assign bus_req  = req_q;
    assign bus_src  = src_q;
    assign bus_dst  = dst_q;
    assign bus_size = ctrl_q.size;
    assign irq      = (ctrl_q.end_flag && ctrl_q.irq_en) ||
                      (ctrl_q.half_flag && ctrl_q.half_ie);

    p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(ctrl_q.chan_en && master_q && !nmi_q && !ae_q));
    p_abort_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (nmi_q || ae_q || !ctrl_q.chan_en || !master_q)) |=> !bus_req);
    p_count_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctrl_q.mode == MODE_NORMAL && !wr_en) |=> (cnt_q == $past(cnt_q) - CW'(1)));
    p_normal_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctrl_q.mode == MODE_NORMAL && cnt_q == CW'(1) && !wr_en) |=> ctrl_q.end_flag);
    p_repeat_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctrl_q.mode == MODE_REPEAT && cnt_q == CW'(1) && !wr_en) |=> (cnt_q == $past(cntb_q)));
    p_one_unit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |=> !bus_req);
endmodule

// File: tb/sim_dma_chan_engine.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_dma_chan_engine;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          dreq = 1'b0;
    logic          nmi_evt = 1'b0;
    logic          addr_err_evt = 1'b0;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [AW-1:0] bus_src, bus_dst;
    logic [1:0]    bus_size;
    logic          irq;
    int            n_total = 0;
    int            n_fail = 0;

    always #10 clk = ~clk;

    dma_chan_engine #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .dreq(dreq), .nmi_evt(nmi_evt),
        .addr_err_evt(addr_err_evt), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .bus_src(bus_src), .bus_dst(bus_dst), .bus_size(bus_size), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Wait for a request, grant one unit, then expect the request low (R11).
    task automatic grant(input string req);
        logic seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            seen = bus_req;
        end
        check({req, " request seen"}, 32'(seen), 32'd1);
        if (seen) begin
            bus_gnt = 1'b1;
            @(negedge clk);
            bus_gnt = 1'b0;
            check("R11 request low after grant", 32'(bus_req), 32'd0);
        end
    endtask

    task automatic expect_idle(input string req, input int cycles);
        logic any = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            any = any | bus_req;
        end
        check({req, " no request"}, 32'(any), 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(3'd3, v);
        check("R2 reset ctrl", v, 32'd0);
        check("R2 reset bus_req", 32'(bus_req), 32'd0);
        check("R10 reset irq", 32'(irq), 32'd0);
    endtask

    task automatic t_normal;
        logic [31:0] v;
        wr(3'd7, 32'h1);
        wr(3'd0, 32'h1000);
        wr(3'd1, 32'h2000);
        wr(3'd2, 32'd3);
        wr(3'd3, 32'h2523);      // auto, size 4, src up, dst down, ie, en
        check("R1 bus_src before unit", bus_src, 32'h1000);
        check("R1 bus_size", 32'(bus_size), 32'd2);
        grant("R1");
        rd(3'd0, v); check("R1 src stepped up", v, 32'h1004);
        rd(3'd1, v); check("R1 dst stepped down", v, 32'h1FFC);
        rd(3'd2, v); check("R1 count down", v, 32'd2);
        grant("R8"); grant("R8");
        rd(3'd2, v); check("R8 count zero", v, 32'd0);
        rd(3'd3, v); check("R8 end flag", 32'(v[3]), 32'd1);
        check("R8 irq", 32'(irq), 32'd1);
        expect_idle("R2 end flag blocks", 10);
        wr(3'd3, 32'h2522);
        rd(3'd3, v); check("R10 end cleared by 0", 32'(v[3]), 32'd0);
        check("R10 irq low", 32'(irq), 32'd0);
        wr(3'd3, 32'h252A);
        rd(3'd3, v); check("R10 writing 1 no effect", 32'(v[3]), 32'd0);
        wr(3'd3, 32'h0);
    endtask

    task automatic t_gate_abort;
        logic [31:0] v;
        wr(3'd7, 32'h0);
        wr(3'd0, 32'h40);
        wr(3'd1, 32'h80);
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h2001);
        expect_idle("R2 global enable off", 8);
        wr(3'd7, 32'h1);
        for (int i = 0; i < 5 && !bus_req; i++) @(negedge clk);
        check("R2 request after enable", 32'(bus_req), 32'd1);
        nmi_evt = 1'b1;
        @(negedge clk);
        nmi_evt = 1'b0;
        @(negedge clk);
        check("R4 request withdrawn", 32'(bus_req), 32'd0);
        rd(3'd2, v); check("R4 count unchanged", v, 32'd2);
        rd(3'd7, v); check("R4 event flag set", 32'(v[1]), 32'd1);
        expect_idle("R4 held off", 5);
        wr(3'd7, 32'h1);
        rd(3'd7, v); check("R10 event flag cleared", 32'(v[1]), 32'd0);
        grant("R4 resume"); grant("R4 resume");
        rd(3'd2, v); check("R4 count after resume", v, 32'd0);
        wr(3'd3, 32'h0);
    endtask

    task automatic t_repeat;
        logic [31:0] v;
        wr(3'd4, 32'h100);
        wr(3'd5, 32'h200);
        wr(3'd6, 32'd4);
        wr(3'd0, 32'h100);
        wr(3'd1, 32'h200);
        wr(3'd2, 32'd4);
        wr(3'd3, 32'h28A7);      // auto, repeat, size 1, both up, hie, ie, en
        grant("R5"); grant("R5");
        rd(3'd2, v); check("R5 count at half", v, 32'd2);
        rd(3'd3, v); check("R5 half flag", 32'(v[4]), 32'd1);
        check("R5 irq on half", 32'(irq), 32'd1);
        rd(3'd0, v); check("R1 src before wrap", v, 32'h102);
        grant("R6"); grant("R6");
        rd(3'd2, v); check("R6 count refilled", v, 32'd4);
        rd(3'd0, v); check("R6 src refilled", v, 32'h100);
        rd(3'd1, v); check("R6 dst refilled", v, 32'h200);
        rd(3'd3, v); check("R6 end flag", 32'(v[3]), 32'd1);
        expect_idle("R3 half flag set blocks", 8);
        wr(3'd3, 32'h28AF);      // keep end flag, clear half flag
        rd(3'd3, v); check("R10 end kept by writing 1", 32'(v[3]), 32'd1);
        grant("R3 accepted with end flag");
        rd(3'd2, v); check("R3 count after accept", v, 32'd3);
        wr(3'd3, 32'h0);
    endtask

    task automatic t_reload;
        logic [31:0] v;
        wr(3'd4, 32'h500);
        wr(3'd5, 32'h600);
        wr(3'd0, 32'h500);
        wr(3'd1, 32'h600);
        wr(3'd2, 32'h020102);
        rd(3'd6, v); check("R7 backup-low field", v, 32'h02000004);
        wr(3'd3, 32'h3221);      // auto, reload, size 2, src up, dst hold, en
        grant("R7"); grant("R7");
        rd(3'd2, v); check("R7 low byte reloaded", v, 32'h020002);
        rd(3'd0, v); check("R7 src back to backup", v, 32'h500);
        rd(3'd1, v); check("R7 dst held", v, 32'h600);
        grant("R7"); grant("R7");
        rd(3'd2, v); check("R7 final count", v, 32'h020000);
        rd(3'd0, v); check("R7 src no refill at end", v, 32'h504);
        rd(3'd3, v); check("R7 end flag", 32'(v[3]), 32'd1);
        expect_idle("R7 stopped", 6);
        wr(3'd3, 32'h0);
    endtask

    task automatic t_dreq;
        logic [31:0] v;
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd2, 32'd3);
        wr(3'd3, 32'h0001);      // level request
        expect_idle("R9 level low", 6);
        dreq = 1'b1;
        grant("R9 level high");
        dreq = 1'b0;
        expect_idle("R9 level released", 6);
        rd(3'd2, v); check("R9 one level unit", v, 32'd2);
        wr(3'd3, 32'h4001);      // edge request
        expect_idle("R9 edge idle", 6);
        dreq = 1'b1;
        grant("R9 edge");
        expect_idle("R9 edge held high", 6);
        dreq = 1'b0;
        @(negedge clk);
        dreq = 1'b1;
        grant("R9 second edge");
        rd(3'd2, v); check("R9 edge count", v, 32'd0);
        dreq = 1'b0;
        wr(3'd3, 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_gate_abort();
        t_repeat();
        t_reload();
        t_dreq();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule